// File: doc/BRIEF.md
# Reed-Solomon Symbol Error Applier

This block takes the output of a Reed-Solomon decoder that works on 12-bit symbols and applies the corrections to a page buffer stored one byte per address. The buffer holds the 2048 page data bytes at addresses 0 to 2047, with the spare-area bytes directly after them, so spare byte k sits at address 2048+k. For each correction the decoder supplies a symbol position and a 12-bit error pattern. The block works out which one or two bytes that symbol covers and XORs the right slice of the pattern into each byte. Each byte is updated with a read-modify-write cycle on a single byte-wide RAM port.

The decoder pulses `start` with a correction count and up to four (position, pattern) pairs. The block latches all of them at that moment and processes the entries in index order. It stops at the first entry it cannot apply. When it has finished, it raises `done` for one cycle and holds the fail flag and the count of corrections it applied until the next start. Because a 12-bit symbol straddles byte boundaries, odd and even positions split differently. Position 0 has only 8 meaningful bits. Symbol 1365 covers the last data byte and the first spare byte.

Top module: `rs_fix_apply`

## Requirements
- R1: A `start` pulse in the idle state latches `errCount`, `errPos` and `errPat`. Changes on these inputs after that cycle, and any `start` pulse before `done`, have no effect on the run.
- R2: For an odd position p, the upper 8 pattern bits are XORed into byte floor(3p/2), and the low 4 pattern bits, placed in the upper nibble of a byte whose lower nibble is zero, are XORed into byte floor(3p/2)+1. Above position 1365 this lands in the spare area (spare byte index = byte address − 2048).
- R3: For an even position p other than 0, the upper 4 pattern bits are XORed into the lower nibble of byte 3p/2−1, and the low 8 pattern bits are XORed into byte 3p/2. No access ever addresses a byte beyond the one that position 1374 reaches (address 2061).
- R4: At position 0 with a pattern no greater than 0xFF, the pattern is XORed into byte 0 alone. A pattern above 0xFF at position 0 is a failure.
- R5: At position 1365, the upper 8 pattern bits go into data byte 2047 and the low nibble, shifted into the upper nibble, goes into spare byte 0 (address 2048).
- R6: A position greater than 1374 is a failure.
- R7: A count above 4 fails at once and changes no byte. A count of 0 finishes without a failure and changes no byte.
- R8: At the first failing entry the block sets `fail` and applies neither that entry nor any later one. Entries already applied stay applied, and `corrCount` equals the number of entries applied (never above 4).
- R9: Each byte update is a read cycle, one idle wait cycle and a write cycle to the same address. Read and write are never asserted together.
- R10: `done` is a one-cycle pulse. It arrives 2 + Σ(1 + 3·b) cycles after the start edge, where b is the number of bytes each applied entry touches (1 for position 0, otherwise 2).
- R11: After reset, `done`, `fail` and `corrCount` are 0 and the RAM port is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin applying a correction set (sampled in idle only) |
| errCount | input | 3 | Number of valid entries |
| errPos | input | 48 | Four 12-bit symbol positions, entry i at bits [12i+11:12i] |
| errPat | input | 48 | Four 12-bit error patterns, entry i at bits [12i+11:12i] |
| memAddr | output | 12 | Buffer byte address |
| memRdEn | output | 1 | Buffer read strobe; data returns on `memRdata` the next cycle |
| memWrEn | output | 1 | Buffer write strobe |
| memWdata | output | 8 | Byte to write |
| memRdata | input | 8 | Byte read from the buffer |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Set when the page could not be corrected |
| corrCount | output | 3 | Number of entries applied |

## Verification
The hardest situation to reach is a run that fails partway through. In that case some bytes have already been written back, the failing entry and the entries after it must leave the buffer untouched, and the cycle count must stop at the failing check. The bench builds correction sets that place an out-of-range position, or an oversized pattern at position 0, after valid entries. It then compares the whole buffer against an arithmetic model. A second situation that needs care is two adjacent positions that share a byte, or one position repeated, where the second read must see the first write. Around these cases the bench sweeps every position from 0 to 1380 as a single correction. It also pokes `start` with altered inputs in the middle of a run.

// File: rtl/rs_fix_pkg.sv
package rs_fix_pkg;
  localparam int SYM_W  = 12;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic load;
    logic beginEntry;
    logic rdEn;
    logic capture;
    logic wrEn;
    logic nextByte;
    logic nextEntry;
    logic setFail;
  } fixCtrl_t;

  typedef struct packed {
    logic cntBad;
    logic atEnd;
    logic entryBad;
    logic lastByte;
  } fixStat_t;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_RD, S_WAIT, S_WR, S_FINISH
  } fixState_t;
endpackage

// File: rtl/rs_fix_ctrl.sv
module rs_fix_ctrl
  import rs_fix_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  fixStat_t stat,
  output fixCtrl_t ctl,
  output logic     done
);
  fixState_t state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    ctl  = '0;
    nxt  = state;
    done = 1'b0;
    case (state)
      S_IDLE: begin
        if (start) begin
          ctl.load = 1'b1;
          nxt      = S_CHECK;
        end
      end
      S_CHECK: begin
        if (stat.cntBad || (!stat.atEnd && stat.entryBad)) begin
          ctl.setFail = 1'b1;
          nxt         = S_FINISH;
        end else if (stat.atEnd) begin
          nxt = S_FINISH;
        end else begin
          ctl.beginEntry = 1'b1;
          nxt            = S_RD;
        end
      end
      S_RD: begin
        ctl.rdEn = 1'b1;
        nxt      = S_WAIT;
      end
      S_WAIT: begin
        ctl.capture = 1'b1;
        nxt         = S_WR;
      end
      S_WR: begin
        ctl.wrEn = 1'b1;
        if (stat.lastByte) begin
          ctl.nextEntry = 1'b1;
          nxt           = S_CHECK;
        end else begin
          ctl.nextByte = 1'b1;
          nxt          = S_RD;
        end
      end
      S_FINISH: begin
        done = 1'b1;
        nxt  = S_IDLE;
      end
      default: nxt = S_IDLE;
    endcase
  end
endmodule

// File: rtl/rs_fix_dpath.sv
module rs_fix_dpath
  import rs_fix_pkg::*;
#(
  parameter int MAX_ERR     = 4,
  parameter int POS_W       = 12,
  parameter int MAX_POS     = 1374,
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  localparam int CNT_W  = $clog2(MAX_ERR + 1),
  localparam int ADDR_W = $clog2(DATA_BYTES + SPARE_BYTES),
  localparam int CALC_W = POS_W + 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  fixCtrl_t                 ctl,
  input  logic [CNT_W-1:0]         errCount,
  input  logic [MAX_ERR*POS_W-1:0] errPos,
  input  logic [MAX_ERR*SYM_W-1:0] errPat,
  input  logic [BYTE_W-1:0]        memRdata,
  output fixStat_t                 stat,
  output logic [ADDR_W-1:0]        memAddr,
  output logic                     memRdEn,
  output logic                     memWrEn,
  output logic [BYTE_W-1:0]        memWdata,
  output logic                     fail,
  output logic [CNT_W-1:0]         corrCount
);
  logic [POS_W-1:0]  posArr [MAX_ERR];
  logic [SYM_W-1:0]  patArr [MAX_ERR];
  logic [CNT_W-1:0]  cntReg, idx, corrReg;
  logic              byteSel, failReg;
  logic [BYTE_W-1:0] rdBuf, xorMask;
  logic [POS_W-1:0]  curPos;
  logic [SYM_W-1:0]  curPat;
  logic [CALC_W-1:0] tripled, halfIdx, baseIdx, byteIdx;

  // Latch the whole correction set at start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MAX_ERR; i++) begin
        posArr[i] <= '0;
        patArr[i] <= '0;
      end
      cntReg <= '0;
    end else if (ctl.load) begin
      for (int i = 0; i < MAX_ERR; i++) begin
        posArr[i] <= errPos[i*POS_W +: POS_W];
        patArr[i] <= errPat[i*SYM_W +: SYM_W];
      end
      cntReg <= errCount;
    end
  end

  // Entry walk, byte select, status
  always_ff @(posedge clk) begin
    if (!rstN) begin
      idx     <= '0;
      corrReg <= '0;
      byteSel <= 1'b0;
      failReg <= 1'b0;
      rdBuf   <= '0;
    end else begin
      if (ctl.load) begin
        idx     <= '0;
        corrReg <= '0;
        failReg <= 1'b0;
      end
      if (ctl.beginEntry) byteSel <= (curPos == '0);
      if (ctl.nextByte)   byteSel <= 1'b1;
      if (ctl.capture)    rdBuf   <= memRdata;
      if (ctl.nextEntry) begin
        idx     <= idx + 1'b1;
        corrReg <= corrReg + 1'b1;
      end
      if (ctl.setFail) failReg <= 1'b1;
    end
  end

  always_comb begin
    curPos = '0;
    curPat = '0;
    for (int i = 0; i < MAX_ERR; i++) begin
      if (idx == CNT_W'(i)) begin
        curPos = posArr[i];
        curPat = patArr[i];
      end
    end
  end

  // Symbol position to linear byte address (spare follows data directly)
  always_comb begin
    tripled = {2'b00, curPos} + {1'b0, curPos, 1'b0};
    halfIdx = tripled >> 1;
    baseIdx = curPos[0] ? halfIdx : halfIdx - 1'b1;
    byteIdx = baseIdx + CALC_W'(byteSel);
  end

  // Pattern slice for the current byte
  always_comb begin
    unique case ({curPos[0], byteSel})
      2'b10:   xorMask = curPat[11:4];
      2'b11:   xorMask = {curPat[3:0], 4'h0};
      2'b00:   xorMask = {4'h0, curPat[11:8]};
      default: xorMask = curPat[7:0];
    endcase
  end

  assign stat.cntBad   = cntReg > CNT_W'(MAX_ERR);
  assign stat.atEnd    = idx == cntReg;
  assign stat.entryBad = (curPos > POS_W'(MAX_POS)) ||
                         ((curPos == '0) && (curPat > SYM_W'(8'hFF)));
  assign stat.lastByte = byteSel;

  assign memAddr   = byteIdx[ADDR_W-1:0];
  assign memRdEn   = ctl.rdEn;
  assign memWrEn   = ctl.wrEn;
  assign memWdata  = rdBuf ^ xorMask;
  assign fail      = failReg;
  assign corrCount = corrReg;
endmodule

// File: rtl/rs_fix_apply.sv
module rs_fix_apply
  import rs_fix_pkg::*;
#(
  parameter int MAX_ERR     = 4,
  parameter int POS_W       = 12,
  parameter int MAX_POS     = 1374,
  parameter int DATA_BYTES  = 2048,
  parameter int SPARE_BYTES = 64,
  localparam int CNT_W  = $clog2(MAX_ERR + 1),
  localparam int ADDR_W = $clog2(DATA_BYTES + SPARE_BYTES)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     start,
  input  logic [CNT_W-1:0]         errCount,
  input  logic [MAX_ERR*POS_W-1:0] errPos,
  input  logic [MAX_ERR*12-1:0]    errPat,
  output logic [ADDR_W-1:0]        memAddr,
  output logic                     memRdEn,
  output logic                     memWrEn,
  output logic [7:0]               memWdata,
  input  logic [7:0]               memRdata,
  output logic                     done,
  output logic                     fail,
  output logic [CNT_W-1:0]         corrCount
);
  fixCtrl_t ctl;
  fixStat_t stat;

  rs_fix_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .stat  (stat),
    .ctl   (ctl),
    .done  (done)
  );

  rs_fix_dpath #(
    .MAX_ERR     (MAX_ERR),
    .POS_W       (POS_W),
    .MAX_POS     (MAX_POS),
    .DATA_BYTES  (DATA_BYTES),
    .SPARE_BYTES (SPARE_BYTES)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .errCount  (errCount),
    .errPos    (errPos),
    .errPat    (errPat),
    .memRdata  (memRdata),
    .stat      (stat),
    .memAddr   (memAddr),
    .memRdEn   (memRdEn),
    .memWrEn   (memWrEn),
    .memWdata  (memWdata),
    .fail      (fail),
    .corrCount (corrCount)
  );
endmodule

// File: rtl/rs_fix_apply_chk.sv
module rs_fix_apply_chk #(
  parameter int MAX_ERR = 4,
  parameter int MAX_POS = 1374,
  parameter int ADDR_W  = 12,
  parameter int CNT_W   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memRdEn,
  input logic              memWrEn,
  input logic              done,
  input logic [CNT_W-1:0]  corrCount
);
  localparam int LAST_ADDR = (3 * MAX_POS) / 2;

  p_rd_wr_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  p_wr_after_wait_r9: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> ($past(memRdEn, 2) && !$past(memRdEn, 1)));

  p_rmw_same_addr_r9: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memAddr == $past(memAddr, 2)));

  p_addr_in_buf_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || memWrEn) |-> (memAddr <= ADDR_W'(LAST_ADDR)));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rstN)
    corrCount <= CNT_W'(MAX_ERR));
endmodule

bind rs_fix_apply rs_fix_apply_chk #(
  .MAX_ERR (MAX_ERR),
  .MAX_POS (MAX_POS),
  .ADDR_W  (ADDR_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memAddr   (memAddr),
  .memRdEn   (memRdEn),
  .memWrEn   (memWrEn),
  .done      (done),
  .corrCount (corrCount)
);

// File: tb/rs_fix_apply_tb.sv
module rs_fix_apply_tb;
  localparam int NBYTES = 2112;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  errCount = '0;
  logic [47:0] errPos = '0;
  logic [47:0] errPat = '0;
  logic [11:0] memAddr;
  logic        memRdEn, memWrEn;
  logic [7:0]  memWdata;
  logic [7:0]  memRdata = '0;
  logic        done, fail;
  logic [2:0]  corrCount;

  logic [7:0]  mem [NBYTES];
  logic [7:0]  expMem [NBYTES];
  logic        initReq = 1'b0;
  int          seed = 0;
  int          vecs = 0;
  int          bad = 0;
  int          protoErr = 0;
  int          casePos [4];
  int          casePat [4];

  always #4 clk = ~clk;

  rs_fix_apply u_dut (
    .clk (clk), .rstN (rstN), .start (start), .errCount (errCount),
    .errPos (errPos), .errPat (errPat), .memAddr (memAddr),
    .memRdEn (memRdEn), .memWrEn (memWrEn), .memWdata (memWdata),
    .memRdata (memRdata), .done (done), .fail (fail), .corrCount (corrCount)
  );

  // Buffer RAM with one-cycle registered read
  always @(posedge clk) begin
    if (initReq) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= 8'(i * 13 + 7 + seed);
    end else begin
      if (memWrEn) mem[memAddr] <= memWdata;
      if (memRdEn) memRdata <= mem[memAddr];
    end
  end

  // R9 port protocol observer
  logic        rd1 = 1'b0, rd2 = 1'b0;
  logic [11:0] a1 = '0, a2 = '0;
  always @(negedge clk) begin
    if (rstN) begin
      if (memRdEn && memWrEn) protoErr++;
      if (memWrEn && !(rd2 && !rd1 && memAddr == a2)) protoErr++;
    end
    rd2 <= rd1; rd1 <= memRdEn;
    a2  <= a1;  a1  <= memAddr;
  end

  task automatic check(input string tag, input int act, input int expv);
    vecs++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // Independent arithmetic model of the correction rules
  task automatic modelApply(input int n, output int eFail, output int eCnt,
                            output int eCost);
    eFail = 0; eCnt = 0; eCost = 0;
    if (n > 4) begin
      eFail = 1;
      return;
    end
    for (int i = 0; i < n; i++) begin
      int p, t, b;
      p = casePos[i];
      t = casePat[i];
      if (p > 1374) begin eFail = 1; return; end
      if (p == 0) begin
        if (t > 255) begin eFail = 1; return; end
        expMem[0] ^= 8'(t);
        eCost += 4;
      end else if (p == 1365) begin
        expMem[2047] ^= 8'(t >> 4);
        expMem[2048] ^= 8'((t & 15) << 4);
        eCost += 7;
      end else begin
        b = (3 * p) / 2;
        if (p % 2 == 1) begin
          expMem[b]     ^= 8'(t >> 4);
          expMem[b + 1] ^= 8'((t & 15) << 4);
        end else begin
          expMem[b - 1] ^= 8'(t >> 8);
          expMem[b]     ^= 8'(t & 255);
        end
        eCost += 7;
      end
      eCnt++;
    end
  endtask

  task automatic runCase(input int n, input bit poke, input string tag);
    int eFail, eCnt, eCost, cyc, mism;
    @(negedge clk);
    seed++;
    initReq = 1'b1;
    @(negedge clk);
    initReq = 1'b0;
    for (int i = 0; i < NBYTES; i++) expMem[i] = 8'(i * 13 + 7 + seed);
    modelApply(n, eFail, eCnt, eCost);
    errCount = 3'(n);
    for (int i = 0; i < 4; i++) begin
      errPos[i*12 +: 12] = 12'(casePos[i]);
      errPat[i*12 +: 12] = 12'(casePat[i]);
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 400) begin
      // R1: a start pulse with altered inputs during the run must be ignored
      start = poke && (cyc == 3);
      if (poke && cyc == 3) begin
        errPos   = ~errPos;
        errPat   = ~errPat;
        errCount = 3'd1;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    if (!done) begin
      check({tag, " R10 timeout waiting for done"}, 0, 1);
      return;
    end
    check({tag, " R10 latency"}, cyc, eCost + 2);
    check({tag, " R8 fail flag"}, int'(fail), eFail);
    check({tag, " R8 corrected count"}, int'(corrCount), eCnt);
    @(negedge clk);
    check({tag, " R10 done single pulse"}, int'(done), 0);
    mism = 0;
    for (int i = 0; i < NBYTES; i++) begin
      if (mem[i] !== expMem[i]) begin
        if (mism == 0)
          $display("FAIL %s: byte %0d actual %0h expected %0h", tag, i,
                   mem[i], expMem[i]);
        mism++;
      end
    end
    check({tag, " buffer mismatches"}, mism, 0);
  endtask

  task automatic setCase(input int p0, input int t0, input int p1, input int t1,
                         input int p2, input int t2, input int p3, input int t3);
    casePos[0] = p0; casePat[0] = t0;
    casePos[1] = p1; casePat[1] = t1;
    casePos[2] = p2; casePat[2] = t2;
    casePos[3] = p3; casePat[3] = t3;
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11 done after reset", int'(done), 0);
    check("R11 fail after reset", int'(fail), 0);
    check("R11 count after reset", int'(corrCount), 0);
    check("R11 port idle after reset", int'(memRdEn | memWrEn), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3 R4 R5 R6: every position alone, 0..1380
    for (int p = 0; p <= 1380; p++) begin
      setCase(p, (p == 0) ? 8'h5A : ((p * 389 + 165) & 12'hFFF), 0, 0, 0, 0, 0, 0);
      runCase(1, 1'b0, $sformatf("R2/R3 sweep pos %0d", p));
    end
    // R4: oversized pattern at position 0 fails
    setCase(0, 12'h1FF, 0, 0, 0, 0, 0, 0);
    runCase(1, 1'b0, "R4 pos0 pattern 0x1FF");
    setCase(0, 12'hFF, 0, 0, 0, 0, 0, 0);
    runCase(1, 1'b0, "R4 pos0 pattern 0xFF");
    // R5 R2 R3: full set of four including the straddle and the last position
    setCase(1, 12'hABC, 2, 12'h123, 1365, 12'hFED, 1374, 12'h0F0);
    runCase(4, 1'b0, "R5 four corrections");
    // R8 R6: failure in the middle
    setCase(10, 12'h3C3, 2000, 12'h111, 7, 12'h222, 0, 0);
    runCase(3, 1'b0, "R8 midway out of range");
    setCase(40, 12'h777, 41, 12'h888, 0, 12'h400, 5, 12'h999);
    runCase(4, 1'b0, "R8 midway pos0 oversized");
    setCase(1375, 12'h001, 3, 12'h002, 0, 0, 0, 0);
    runCase(2, 1'b0, "R6 first entry 1375");
    // R7: count out of bounds and zero
    setCase(4, 12'hFFF, 6, 12'hFFF, 8, 12'hFFF, 9, 12'hFFF);
    runCase(5, 1'b0, "R7 count 5");
    runCase(7, 1'b0, "R7 count 7");
    runCase(0, 1'b0, "R7 count 0");
    // R2 R3: neighbours sharing a byte, repeated position
    setCase(5, 12'hA5F, 6, 12'h36C, 0, 0, 0, 0);
    runCase(2, 1'b0, "R3 shared byte");
    setCase(1367, 12'h5A5, 1367, 12'h5A5, 1368, 12'hF0F, 0, 12'h0FF);
    runCase(4, 1'b0, "R2 repeat spare");
    // R1: start while busy with altered inputs
    setCase(100, 12'h1E1, 201, 12'h2D2, 0, 0, 0, 0);
    runCase(2, 1'b1, "R1 start while busy");
    setCase(0, 12'h0C3, 1364, 12'hE17, 1366, 12'h7E1, 0, 0);
    runCase(3, 1'b1, "R1 start while busy 3");

    check("R9 read-wait-write protocol violations", protoErr, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule